// File: doc/BRIEF.md
# Register-List Transfer Sequencer

This block runs the multi-register memory transfers of a 16-bit compressed instruction set. It handles two families of instruction. The first is a block transfer that uses any of the eight low registers as its base. The second is a stack transfer that uses the stack pointer, register 13. The sequencer walks the 8-bit register list and issues one word request at a time on a simple request/ready memory port. Load data is written into the register file when the memory returns it. When the list is finished, the sequencer writes the updated base or stack pointer back.

The surrounding core starts a transfer by pulsing `start_i` with the instruction halfword while the sequencer is idle. The core supplies the current program-counter value on `pc_i`. The core also provides one combinational register-file read port and one write port. A `done_o` pulse marks the writeback cycle, and `branch_o` flags any load into the program counter so the core can redirect fetch. All addresses are word aligned and advance in steps of 4 bytes.

Top module: `rlx_seq`

## Requirements
- R1: Decode works as follows. Bit 14 set selects the block transfer and bit 14 clear selects the stack transfer. Bit 11 set means load. Bits 7:0 are the list, where bit k stands for register k. For block transfers, bits 10:8 name the base register. For stack transfers, the base is register 13 and bit 8 adds register 14 to a store or register 15 to a load.
- R2: A block transfer with a non-empty list moves the listed registers in order from lowest to highest index. The addresses start at the base value and go up by 4 for each register.
- R3: Every transfer ends with a single cycle in which the base register (or register 13) is written with its final address. `done_o` is high in that cycle only.
- R4: Consider a block store whose base register is in the list. If the base is the first register transferred, the word stored for it is its original value. Otherwise the word stored for it is the final written-back address.
- R5: A block load with an empty list loads register 15 from the base address and raises `branch_o`. The base is then written back as base + 0x40.
- R6: A block store with an empty list stores `pc_i` + 2 at the base address. The base is then written back as base + 0x40.
- R7: A stack store writes register 14 first, at SP−4, when bit 8 is set. It then stores the listed registers from index 7 down to index 0 at addresses that go down by 4. The final SP is the lowest address written.
- R8: A stack load reads the listed registers from SP upward in order of increasing index. When bit 8 is set, it then loads register 15 from the next word with `branch_o` high. The final SP is one word past the last word read.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the request and its address and direction stay unchanged in the next cycle.
- R10: A load writes the register file only in a cycle where `mem_rvalid_i` is high. The sequencer never asserts `mem_req_o` and `rf_we_o` in the same cycle.
- R11: While idle, the outputs `mem_req_o` and `rf_we_o` stay low. A `start_i` pulse that arrives while `busy_o` is high is ignored.
- R12: A stack transfer with an empty list and bit 8 clear makes no memory access. It writes register 13 back unchanged and raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begin a transfer (accepted only when idle) |
| instr_i | input | 16 | Instruction halfword |
| pc_i | input | 32 | Current program-counter value |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Base/SP writeback cycle |
| branch_o | output | 1 | Register 15 is being loaded |
| rf_raddr_o | output | 4 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a store |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Store data |
| mem_ready_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Load data valid |
| mem_rdata_i | input | 32 | Load data |

## Verification
The main function is driven with several kinds of register list:
- a scattered list, which separates the ordering rule from any contiguous-range shortcut;
- a store with the base register in the middle of the list, which checks the stored value against the final written-back address;
- the same store with the base register first in the list, which checks that the original value is stored instead;
- empty lists, which exercise the fixed 0x40 increment and the program-counter transfer.

Stack transfers are run in pairs. A push is followed by a pop of the same list, so the placement of register 14 at the top and the order of the listed registers must match for the pop to return the pushed data. Full lists are run with memory stalls and delayed load data to separate request holding from data capture. A second start pulse arrives during a transfer and must leave no trace.

// File: rtl/rlx_pkg.sv
package rlx_pkg;
    localparam int XLEN        = 32;
    localparam int LIST_W      = 8;
    localparam int SLOTS       = LIST_W + 1;
    localparam int SLOT_W      = $clog2(SLOTS);
    localparam int IDX_W       = 4;
    localparam int CNT_W       = $clog2(SLOTS + 1);
    localparam int WORD_BYTES  = 4;
    localparam int EMPTY_WORDS = 16;
    localparam int PC_ADVANCE  = 2;
    localparam logic [IDX_W-1:0] SP_IDX = 4'd13;
    localparam logic [IDX_W-1:0] LR_IDX = 4'd14;
    localparam logic [IDX_W-1:0] PC_IDX = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_WAIT,
        ST_WB
    } seq_state_e;

    typedef struct packed {
        seq_state_e          state;
        logic [SLOTS-1:0]    mask;
        logic [XLEN-1:0]     addr;
        logic [XLEN-1:0]     fin;
        logic [XLEN-1:0]     pc;
        logic [IDX_W-1:0]    base_idx;
        logic [IDX_W-1:0]    cur_reg;
        logic                is_load;
        logic                is_push;
        logic                first;
    } seq_regs_t;
endpackage

// File: rtl/rlx_pick.sv
module rlx_pick #(
    parameter int N          = 9,
    parameter bit HIGH_FIRST = 1'b0,
    localparam int IW        = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    assign any = |mask;

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (mask[i]) idx = IW'(i);
                end
            end
        end else begin : g_low
            always_comb begin
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (mask[i]) idx = IW'(i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rlx_span.sv
module rlx_span
    import rlx_pkg::*;
(
    input  logic [14:0]      instr,
    input  logic [XLEN-1:0]  base_val,
    output logic [SLOTS-1:0] mask,
    output logic [IDX_W-1:0] base_idx,
    output logic [XLEN-1:0]  start_addr,
    output logic [XLEN-1:0]  fin_addr,
    output logic             is_load,
    output logic             is_push
);
    logic              block_xfer;
    logic [LIST_W-1:0] list;
    logic              extra;
    logic [CNT_W-1:0]  cnt;
    logic [XLEN-1:0]   span_bytes;

    assign block_xfer = instr[14];
    assign list       = instr[LIST_W-1:0];
    assign extra      = block_xfer ? (list == '0) : instr[8];
    assign is_load    = instr[11];
    assign is_push    = !block_xfer && !instr[11];
    assign base_idx   = block_xfer ? {1'b0, instr[10:8]} : SP_IDX;
    assign mask       = {extra, list};

    always_comb begin
        cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cnt = cnt + CNT_W'(mask[i]);
        end
    end

    assign span_bytes = (block_xfer && list == '0)
                      ? XLEN'(EMPTY_WORDS * WORD_BYTES)
                      : (XLEN'(cnt) * XLEN'(WORD_BYTES));

    always_comb begin
        if (is_push) begin
            start_addr = base_val - XLEN'(WORD_BYTES);
            fin_addr   = base_val - span_bytes;
        end else begin
            start_addr = base_val;
            fin_addr   = base_val + span_bytes;
        end
    end
endmodule

// File: rtl/rlx_seq.sv
module rlx_seq
    import rlx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [15:0]      instr_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             branch_o,
    output logic [IDX_W-1:0] rf_raddr_o,
    input  logic [XLEN-1:0]  rf_rdata_i,
    output logic             rf_we_o,
    output logic [IDX_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0]  rf_wdata_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [XLEN-1:0]  mem_addr_o,
    output logic [XLEN-1:0]  mem_wdata_o,
    input  logic             mem_ready_i,
    input  logic             mem_rvalid_i,
    input  logic [XLEN-1:0]  mem_rdata_i
);
    seq_regs_t q, d;

    logic              unused_opcode;
    logic [SLOTS-1:0]  sp_mask;
    logic [IDX_W-1:0]  sp_base_idx;
    logic [XLEN-1:0]   sp_start, sp_fin;
    logic              sp_load, sp_push;
    logic [SLOT_W-1:0] lo_idx, hi_idx, slot;
    logic              lo_any, hi_any;
    logic [IDX_W-1:0]  reg_idx;
    logic [SLOTS-1:0]  mask_left;

    assign unused_opcode = ^{instr_i[15], instr_i[13:12]};

    rlx_span u_span (
        .instr      (instr_i[14:0]),
        .base_val   (rf_rdata_i),
        .mask       (sp_mask),
        .base_idx   (sp_base_idx),
        .start_addr (sp_start),
        .fin_addr   (sp_fin),
        .is_load    (sp_load),
        .is_push    (sp_push)
    );

    rlx_pick #(.N(SLOTS), .HIGH_FIRST(1'b0)) u_pick_lo (
        .mask (q.mask),
        .idx  (lo_idx),
        .any  (lo_any)
    );

    rlx_pick #(.N(SLOTS), .HIGH_FIRST(1'b1)) u_pick_hi (
        .mask (q.mask),
        .idx  (hi_idx),
        .any  (hi_any)
    );

    always_comb begin
        slot = q.is_push ? hi_idx : lo_idx;
        if (slot == SLOT_W'(SLOTS - 1)) begin
            reg_idx = q.is_push ? LR_IDX : PC_IDX;
        end else begin
            reg_idx = IDX_W'(slot);
        end
        mask_left       = q.mask;
        mask_left[slot] = 1'b0;
    end

    always_comb begin
        d           = q;
        busy_o      = (q.state != ST_IDLE);
        done_o      = 1'b0;
        branch_o    = 1'b0;
        rf_raddr_o  = reg_idx;
        rf_we_o     = 1'b0;
        rf_waddr_o  = q.base_idx;
        rf_wdata_o  = q.fin;
        mem_req_o   = 1'b0;
        mem_we_o    = !q.is_load;
        mem_addr_o  = q.addr;
        mem_wdata_o = '0;

        case (q.state)
            ST_IDLE: begin
                rf_raddr_o = sp_base_idx;
                if (start_i) begin
                    d.mask     = sp_mask;
                    d.addr     = sp_start;
                    d.fin      = sp_fin;
                    d.pc       = pc_i;
                    d.base_idx = sp_base_idx;
                    d.cur_reg  = '0;
                    d.is_load  = sp_load;
                    d.is_push  = sp_push;
                    d.first    = 1'b1;
                    d.state    = (sp_mask == '0) ? ST_WB : ST_XFER;
                end
            end
            ST_XFER: begin
                mem_req_o = 1'b1;
                if (!q.is_push && slot == SLOT_W'(SLOTS - 1)) begin
                    mem_wdata_o = q.pc + XLEN'(PC_ADVANCE);
                end else if (reg_idx == q.base_idx && !q.first) begin
                    mem_wdata_o = q.fin;
                end else begin
                    mem_wdata_o = rf_rdata_i;
                end
                if (mem_ready_i) begin
                    d.mask    = mask_left;
                    d.first   = 1'b0;
                    d.cur_reg = reg_idx;
                    d.addr    = q.is_push ? q.addr - XLEN'(WORD_BYTES)
                                          : q.addr + XLEN'(WORD_BYTES);
                    if (q.is_load) begin
                        d.state = ST_WAIT;
                    end else begin
                        d.state = (mask_left == '0) ? ST_WB : ST_XFER;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    rf_we_o    = 1'b1;
                    rf_waddr_o = q.cur_reg;
                    rf_wdata_o = mem_rdata_i;
                    branch_o   = (q.cur_reg == PC_IDX);
                    d.state    = (q.mask == '0) ? ST_WB : ST_XFER;
                end
            end
            ST_WB: begin
                rf_we_o = 1'b1;
                done_o  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // R9: an unaccepted request is held unchanged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    // R10: load data reaches the register file only with valid read data
    p_load_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o && !done_o |-> mem_rvalid_i);

    // R10: memory and register-file writes never overlap
    p_port_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && rf_we_o));

    // R3: done lasts one cycle and carries a register write
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rf_we_o ##1 !done_o);

    // R8: branch strobe only with a write to register 15
    p_branch_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> rf_we_o && rf_waddr_o == PC_IDX);

    // R11: idle means no activity on either port
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o && !rf_we_o);

    // R11: a busy sequencer finishes with a done pulse before idling
    p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);
endmodule

// File: tb/rlx_seq_test.sv
module rlx_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] pc = 32'h0000_1234;
    logic        busy, done, branch, rf_we, mem_req, mem_we;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata;
    logic        mem_ready = 1'b0, mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    rlx_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr), .pc_i(pc),
        .busy_o(busy), .done_o(done), .branch_o(branch),
        .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
        .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
    );

    logic [31:0] regs [16];
    logic [31:0] mem  [64];

    typedef struct {
        bit          is_rf;
        bit          we;
        logic [3:0]  ra;
        logic [31:0] a;
        logic [31:0] d;
        bit          br;
        bit          dn;
        string       tag;
    } ev_t;
    ev_t exp_q[$];

    int errors = 0;
    int checks = 0;
    int stall  = 0;
    int rv_dly = 0;
    int cyc    = 0;

    always_comb rf_rdata = regs[rf_raddr];

    function automatic int widx(logic [31:0] a);
        return int'(a[7:2]);
    endfunction

    // memory model: inputs change on the falling edge
    bit          acc_we, rv_pend;
    logic [31:0] acc_a, acc_d;
    int          wcnt = 0, rv_cnt = 0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rv_pend) begin
            if (rv_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = mem[widx(acc_a)];
                rv_pend    = 1'b0;
            end else rv_cnt--;
        end
        if (mem_ready) begin
            if (acc_we) mem[widx(acc_a)] = acc_d;
            else begin rv_pend = 1'b1; rv_cnt = rv_dly; end
            mem_ready = 1'b0;
            wcnt = stall;
        end else if (mem_req && rst_n) begin
            if (wcnt == 0) begin
                mem_ready = 1'b1;
                acc_we = mem_we; acc_a = mem_addr; acc_d = mem_wdata;
            end else wcnt--;
        end
    end

    task automatic fail(string req, string what, logic [31:0] act, logic [31:0] exp);
        errors++;
        $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    endtask

    task automatic check_ev(bit is_rf);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fail("R11", is_rf ? "unexpected rf write" : "unexpected mem access",
                 is_rf ? rf_wdata : mem_addr, 32'h0);
            return;
        end
        e = exp_q.pop_front();
        if (e.is_rf != is_rf) begin
            fail(e.tag, "event kind", 32'(is_rf), 32'(e.is_rf));
        end else if (is_rf) begin
            if (rf_waddr != e.ra) fail(e.tag, "rf index", 32'(rf_waddr), 32'(e.ra));
            else if (rf_wdata != e.d) fail(e.tag, "rf data", rf_wdata, e.d);
            else if (branch != e.br) fail(e.tag, "branch strobe", 32'(branch), 32'(e.br));
            else if (done != e.dn) fail(e.tag, "done pulse", 32'(done), 32'(e.dn));
        end else begin
            if (mem_we != e.we) fail(e.tag, "direction", 32'(mem_we), 32'(e.we));
            else if (mem_addr != e.a) fail(e.tag, "address", mem_addr, e.a);
            else if (e.we && mem_wdata != e.d) fail(e.tag, "store data", mem_wdata, e.d);
        end
    endtask

    // monitor: samples 2 ns after the falling edge
    bit          hold_chk = 1'b0;
    logic [31:0] hold_a;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (hold_chk) begin
                checks++;
                if (!(mem_req && mem_addr == hold_a))
                    fail("R9", "held request", mem_addr, hold_a);
            end
            hold_chk = mem_req && !mem_ready;
            hold_a   = mem_addr;
            if (mem_req && mem_ready) check_ev(1'b0);
            if (rf_we) begin
                if (!done) begin
                    checks++;
                    if (!mem_rvalid) fail("R10", "write without rvalid", 32'(mem_rvalid), 32'd1);
                end
                check_ev(1'b1);
                regs[rf_waddr] = rf_wdata;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic void add_mem(bit we, logic [31:0] a, logic [31:0] d, string tag);
        ev_t e;
        e.is_rf = 0; e.we = we; e.ra = 0; e.a = a; e.d = d; e.br = 0; e.dn = 0; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    function automatic void add_rf(logic [3:0] ra, logic [31:0] d, bit br, bit dn, string tag);
        ev_t e;
        e.is_rf = 1; e.we = 0; e.ra = ra; e.a = 0; e.d = d; e.br = br; e.dn = dn; e.tag = tag;
        exp_q.push_back(e);
    endfunction

    // expected behaviour straight from the requirements
    function automatic void predict(logic [15:0] ins, string tag);
        logic [7:0]  list = ins[7:0];
        bit          ld   = ins[11];
        logic [31:0] a, fin, base;
        int          n = 0;
        bit          first = 1;
        for (int i = 0; i < 8; i++) n += int'(list[i]);
        if (ins[14]) begin
            logic [3:0] b = {1'b0, ins[10:8]};
            base = regs[b];
            if (list == 0) begin
                if (ld) begin
                    add_mem(0, base, 0, tag);
                    add_rf(4'd15, mem[widx(base)], 1, 0, tag);
                end else add_mem(1, base, pc + 32'd2, tag);
                add_rf(b, base + 32'h40, 0, 1, tag);
            end else begin
                fin = base + 32'(4 * n);
                a = base;
                for (int i = 0; i < 8; i++) begin
                    if (list[i]) begin
                        if (ld) begin
                            add_mem(0, a, 0, tag);
                            add_rf(4'(i), mem[widx(a)], 0, 0, tag);
                        end else begin
                            add_mem(1, a, (4'(i) == b && !first) ? fin : regs[i], tag);
                        end
                        first = 0;
                        a += 32'd4;
                    end
                end
                add_rf(b, fin, 0, 1, tag);
            end
        end else begin
            a = regs[13];
            if (!ld) begin
                if (ins[8]) begin a -= 32'd4; add_mem(1, a, regs[14], tag); end
                for (int i = 7; i >= 0; i--) begin
                    if (list[i]) begin a -= 32'd4; add_mem(1, a, regs[i], tag); end
                end
            end else begin
                for (int i = 0; i < 8; i++) begin
                    if (list[i]) begin
                        add_mem(0, a, 0, tag);
                        add_rf(4'(i), mem[widx(a)], 0, 0, tag);
                        a += 32'd4;
                    end
                end
                if (ins[8]) begin
                    add_mem(0, a, 0, tag);
                    add_rf(4'd15, mem[widx(a)], 1, 0, tag);
                    a += 32'd4;
                end
            end
            add_rf(4'd13, a, 0, 1, tag);
        end
    endfunction

    task automatic go(logic [15:0] ins, string tag, bit intrude);
        int  k;
        bit  finished = 0;
        predict(ins, tag);
        @(negedge clk);
        start = 1'b1; instr = ins;
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            @(negedge clk);
            start = 1'b1; instr = 16'hC8FF;
            @(negedge clk);
            start = 1'b0; instr = ins;
        end
        for (k = 0; k < 3000 && !finished; k++) begin
            @(negedge clk);
            #3;
            if (exp_q.size() == 0 && !busy) finished = 1;
        end
        repeat (4) @(negedge clk);
        checks++;
        if (!finished || exp_q.size() != 0 || busy) begin
            fail(tag, "transfer incomplete", 32'(exp_q.size()), 32'd0);
            exp_q.delete();
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h111;
        for (int i = 0; i < 64; i++) mem[i] = 32'hA5C3_0000 | 32'(i << 2);
        repeat (3) @(negedge clk);
        #2;
        checks++;
        if (busy || mem_req || rf_we || done || branch)
            fail("R11", "reset state", {27'd0, busy, mem_req, rf_we, done, branch}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        regs[0] = 32'h20;
        go(16'hC8A6, "R1 R2 block load scattered list", 0);
        regs[3] = 32'h40;
        go(16'hC34A, "R4 R3 block store base in middle", 0);
        regs[2] = 32'h60;
        go(16'hC214, "R4 block store base first", 0);
        regs[4] = 32'h30;
        go(16'hCC00, "R5 empty block load", 0);
        regs[5] = 32'h80;
        go(16'hC500, "R6 empty block store", 0);
        regs[13] = 32'hA0;
        go(16'hB509, "R7 push with link", 0);
        go(16'hBD09, "R8 pop with pc", 0);
        go(16'hB400, "R12 empty push", 0);
        go(16'hBC00, "R12 empty pop", 0);
        stall = 2; rv_dly = 2;
        go(16'hB4FF, "R7 R9 full push stalled", 0);
        go(16'hBCFF, "R8 R10 full pop delayed data", 0);
        stall = 1; rv_dly = 0;
        regs[1] = 32'h10;
        go(16'hC10F, "R11 start while busy ignored", 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule